// File: doc/BRIEF.md
# Debug memory access command engine

This engine carries out host debug commands against target memory while the processor keeps running. A host-side front end hands it an 8-bit opcode on one strobe, then 16-bit operands on a second strobe: an address for every memory command, followed by a data word for writes. The engine turns each memory command into one request on a bus-access port. It holds that request until the bus grants it and returns read data to the host as a 16-bit word.

Byte commands use one lane of the 16-bit word, chosen by the parity of the address. Word commands use both lanes and are always issued aligned. Commands of the private-register class raise a separate select for the length of their one access, so they reach debug registers that sit at the same addresses as application memory. The engine can also emit a one-cycle handshake pulse on completion, which the host turns on and off at runtime. A halt command asks the processor to enter debug mode, but only when the firmware-enable input is set.

The controller has six states. In ST_IDLE it waits for an opcode. Memory opcodes go to ST_TAKE_ADDR, which goes to ST_TAKE_DATA for writes or straight to ST_ACCESS for reads. ST_TAKE_DATA goes to ST_ACCESS. ST_ACCESS goes to ST_REPLY on grant. The two handshake opcodes go directly to ST_REPLY. An enabled halt goes to ST_WAIT_HALT, which goes to ST_REPLY once the processor reports entry. ST_REPLY always returns to ST_IDLE. Unknown opcodes, and a halt without firmware enable, leave the engine in ST_IDLE.

Top module: `dbg_cmd_engine`

## Requirements
- R1: The engine recognises opcode 0x90 (halt), 0xD5 (handshake on), 0xD6 (handshake off), reads 0xE0 (byte), 0xE8 (word), 0xE4 (private byte) and 0xEC (private word), and writes 0xC0 (byte), 0xC8 (word), 0xC4 (private byte) and 0xCC (private word). Any other opcode is dropped: busy stays low, and no bus request and no handshake pulse follow.
- R2: A read takes one address operand and then shows the data read on `rd_data`, with `rd_valid` high for exactly one cycle. A write takes an address operand and then a data operand.
- R3: Byte accesses work on lanes. An odd address uses bits 7:0 (`mem_be` = 01). An even address uses bits 15:8 (`mem_be` = 10). Byte reads return zero in the unused lane, and the unused lane of a byte write leaves memory unchanged.
- R4: Word accesses use `mem_be` = 11, and the engine clears address bit 0, so a word read at an odd address returns the aligned word.
- R5: `mem_bdsel` is high only while a request from a private-class opcode is on the bus. Other commands never raise it and always reach application memory.
- R6: With the handshake on, `ack` pulses for one cycle: in the same cycle as `rd_valid` for reads, in the cycle after the grant for writes, and in the cycle after the opcode for the handshake-on command.
- R7: The handshake is off after reset. Opcode 0xD6 turns it off and produces no pulse.
- R8: When `fw_enable` is high as the halt opcode is accepted, the halt command raises `halt_req` until `halt_done`. The handshake pulse, if on, follows entry into debug mode. When `fw_enable` is low the command does nothing.
- R9: `busy` is high from the cycle after an opcode is accepted until the command completes. It is low after reset.
- R10: A bus request stays up, with a stable address and direction, until `mem_gnt` is seen, however many wait cycles the bus inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opc_valid | input | 1 | Opcode strobe, sampled in idle |
| opc | input | 8 | Command opcode |
| arg_valid | input | 1 | Operand strobe |
| arg_data | input | 16 | Address or write-data operand |
| fw_enable | input | 1 | Firmware enable for the halt command |
| halt_req | output | 1 | Request to enter debug mode |
| halt_done | input | 1 | Processor has entered debug mode |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Access is a write |
| mem_bdsel | output | 1 | Select the private debug register space |
| mem_addr | output | 16 | Access address |
| mem_be | output | 2 | Byte lane enables (bit 1 = high byte) |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Bus accepted the request this cycle |
| mem_rdata | input | 16 | Read data, valid with the grant |
| rd_data | output | 16 | Read result returned to the host |
| rd_valid | output | 1 | Read result valid for one cycle |
| ack | output | 1 | Handshake pulse |
| busy | output | 1 | Command in progress |

## Verification
The bench targets lane placement with byte writes whose unused lane holds junk, then reads the word back. A design that ignored the enables, or swapped the parity mapping, would corrupt the neighbouring byte or return data on the wrong lane. Writes to the private space at addresses that overlap application data are read back through both paths. Leaking the select would overwrite application data, and dropping it would read the wrong space. A word read at an odd address would return the wrong word if alignment were skipped. A long grant delay catches a request that drops or drifts, and handshake tests before and after the toggle commands catch a wrong reset value or a pulse from the disable command. Unknown opcodes, and a halt without firmware enable, must leave `busy` and the bus untouched.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam logic [7:0] OPC_HALT     = 8'h90;
    localparam logic [7:0] OPC_HS_ON    = 8'hD5;
    localparam logic [7:0] OPC_HS_OFF   = 8'hD6;
    localparam logic [7:0] OPC_RD8      = 8'hE0;
    localparam logic [7:0] OPC_RD16     = 8'hE8;
    localparam logic [7:0] OPC_RD8_PRV  = 8'hE4;
    localparam logic [7:0] OPC_RD16_PRV = 8'hEC;
    localparam logic [7:0] OPC_WR8      = 8'hC0;
    localparam logic [7:0] OPC_WR16     = 8'hC8;
    localparam logic [7:0] OPC_WR8_PRV  = 8'hC4;
    localparam logic [7:0] OPC_WR16_PRV = 8'hCC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE_ADDR,
        ST_TAKE_DATA,
        ST_ACCESS,
        ST_REPLY,
        ST_WAIT_HALT
    } eng_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_HALT,
        K_HS_ON,
        K_HS_OFF,
        K_READ,
        K_WRITE
    } cmd_kind_t;

    typedef struct packed {
        cmd_kind_t kind;
        logic      is_byte;
        logic      priv;
    } cmd_info_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [7:0] opc,
    output cmd_info_t  info
);

    always_comb begin
        info = '{kind: K_NONE, is_byte: 1'b0, priv: 1'b0};
        case (opc)
            OPC_HALT:     info.kind = K_HALT;
            OPC_HS_ON:    info.kind = K_HS_ON;
            OPC_HS_OFF:   info.kind = K_HS_OFF;
            OPC_RD8:      info = '{kind: K_READ,  is_byte: 1'b1, priv: 1'b0};
            OPC_RD16:     info = '{kind: K_READ,  is_byte: 1'b0, priv: 1'b0};
            OPC_RD8_PRV:  info = '{kind: K_READ,  is_byte: 1'b1, priv: 1'b1};
            OPC_RD16_PRV: info = '{kind: K_READ,  is_byte: 1'b0, priv: 1'b1};
            OPC_WR8:      info = '{kind: K_WRITE, is_byte: 1'b1, priv: 1'b0};
            OPC_WR16:     info = '{kind: K_WRITE, is_byte: 1'b0, priv: 1'b0};
            OPC_WR8_PRV:  info = '{kind: K_WRITE, is_byte: 1'b1, priv: 1'b1};
            OPC_WR16_PRV: info = '{kind: K_WRITE, is_byte: 1'b0, priv: 1'b1};
            default:      info.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/dbg_byte_lane.sv
module dbg_byte_lane #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                   is_byte,
    input  logic [ADDR_W-1:0]      addr_in,
    input  logic [DATA_W-1:0]      wdata_in,
    input  logic [DATA_W-1:0]      rdata_in,
    output logic [ADDR_W-1:0]      addr_out,
    output logic [DATA_W/8-1:0]    be_out,
    output logic [DATA_W-1:0]      wdata_out,
    output logic [DATA_W-1:0]      rdata_out
);

    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = $clog2(LANES);

    logic [SEL_W-1:0] lane_ofs;
    assign lane_ofs = addr_in[SEL_W-1:0];

    // Word accesses are forced onto a full-bus boundary.
    assign addr_out = is_byte ? addr_in : {addr_in[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};

    // Lowest address maps to the most significant lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_out[g] = !is_byte || (lane_ofs == SEL_W'(LANES - 1 - g));
        assign wdata_out[g*8 +: 8] = be_out[g] ? wdata_in[g*8 +: 8] : 8'h00;
        assign rdata_out[g*8 +: 8] = be_out[g] ? rdata_in[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                opc_valid,
    input  logic [7:0]          opc,
    input  logic                arg_valid,
    input  logic [DATA_W-1:0]   arg_data,
    input  logic                fw_enable,
    output logic                halt_req,
    input  logic                halt_done,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_bdsel,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                ack,
    output logic                busy
);

    localparam int BE_W = DATA_W / 8;

    eng_state_t        st_q, st_d;
    cmd_info_t         dec_info, info_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q, rdat_q, lane_rdata;
    logic              hs_en_q;

    dbg_cmd_decode i_decode (
        .opc  (opc),
        .info (dec_info)
    );

    dbg_byte_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lane (
        .is_byte   (info_q.is_byte),
        .addr_in   (addr_q),
        .wdata_in  (wdat_q),
        .rdata_in  (mem_rdata),
        .addr_out  (mem_addr),
        .be_out    (mem_be),
        .wdata_out (mem_wdata),
        .rdata_out (lane_rdata)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (opc_valid) begin
                    case (dec_info.kind)
                        K_READ, K_WRITE:  st_d = ST_TAKE_ADDR;
                        K_HS_ON, K_HS_OFF: st_d = ST_REPLY;
                        K_HALT:           st_d = fw_enable ? ST_WAIT_HALT : ST_IDLE;
                        default:          st_d = ST_IDLE;
                    endcase
                end
            end
            ST_TAKE_ADDR: if (arg_valid) st_d = (info_q.kind == K_WRITE) ? ST_TAKE_DATA : ST_ACCESS;
            ST_TAKE_DATA: if (arg_valid) st_d = ST_ACCESS;
            ST_ACCESS:    if (mem_gnt)   st_d = ST_REPLY;
            ST_WAIT_HALT: if (halt_done) st_d = ST_REPLY;
            ST_REPLY:     st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q  <= '{kind: K_NONE, is_byte: 1'b0, priv: 1'b0};
            addr_q  <= '0;
            wdat_q  <= '0;
            rdat_q  <= '0;
            hs_en_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && opc_valid) begin
                info_q <= dec_info;
                if (dec_info.kind == K_HS_ON)  hs_en_q <= 1'b1;
                if (dec_info.kind == K_HS_OFF) hs_en_q <= 1'b0;
            end
            if (st_q == ST_TAKE_ADDR && arg_valid) addr_q <= arg_data[ADDR_W-1:0];
            if (st_q == ST_TAKE_DATA && arg_valid) wdat_q <= arg_data;
            if (st_q == ST_ACCESS && mem_gnt && info_q.kind == K_READ) rdat_q <= lane_rdata;
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_req   = (st_q == ST_ACCESS);
        mem_we    = (st_q == ST_ACCESS) && (info_q.kind == K_WRITE);
        mem_bdsel = (st_q == ST_ACCESS) && info_q.priv;
        halt_req  = (st_q == ST_WAIT_HALT);
        ack       = (st_q == ST_REPLY) && hs_en_q;
        rd_valid  = (st_q == ST_REPLY) && (info_q.kind == K_READ);
        rd_data   = rdat_q;
    end

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !ack && !rd_valid && !halt_req);                          // R1
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                                        // R2
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == {BE_W{1'b1}}) || ($countones(mem_be) == 1));              // R3
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == {BE_W{1'b1}}) |-> !mem_addr[0]);                          // R4
    AST_PRIV_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bdsel |-> mem_req);                                                         // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                                                  // R6
    AST_HALT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(fw_enable));                                          // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));     // R10

endmodule

// File: tb/test_dbg_cmd_engine.sv
module test_dbg_cmd_engine;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  opc;
        logic [15:0] addr;
        logic [15:0] wdat;
        logic [15:0] exp;
        logic        exp_ack;
    } vec_t;

    // Handshake is on from entry 0 onward.
    localparam vec_t VECS [14] = '{
        '{8'hD5, 16'h0000, 16'h0000, 16'h0000, 1'b1},
        '{8'hC8, 16'h0010, 16'h1234, 16'h0000, 1'b1},
        '{8'hE8, 16'h0010, 16'h0000, 16'h1234, 1'b1},
        '{8'hC0, 16'h0012, 16'hABFF, 16'h0000, 1'b1},
        '{8'hC0, 16'h0013, 16'hEECD, 16'h0000, 1'b1},
        '{8'hE8, 16'h0012, 16'h0000, 16'hABCD, 1'b1},
        '{8'hE0, 16'h0013, 16'h0000, 16'h00CD, 1'b1},
        '{8'hE0, 16'h0012, 16'h0000, 16'hAB00, 1'b1},
        '{8'hCC, 16'h0010, 16'h5A5A, 16'h0000, 1'b1},
        '{8'hEC, 16'h0010, 16'h0000, 16'h5A5A, 1'b1},
        '{8'hE8, 16'h0010, 16'h0000, 16'h1234, 1'b1},
        '{8'hE8, 16'h0011, 16'h0000, 16'h1234, 1'b1},
        '{8'hC4, 16'h0015, 16'h0077, 16'h0000, 1'b1},
        '{8'hE4, 16'h0014, 16'h0000, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opc_valid = 1'b0;
    logic [7:0]  opc = 8'h00;
    logic        arg_valid = 1'b0;
    logic [15:0] arg_data = 16'h0000;
    logic        fw_enable = 1'b0;
    logic        halt_req, halt_done;
    logic        mem_req, mem_we, mem_bdsel, mem_gnt;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rd_data;
    logic [1:0]  mem_be;
    logic        rd_valid, ack, busy;

    int n_chk = 0;
    int n_fail = 0;
    int gnt_delay = 0;
    int halt_delay = 0;
    int wait_cnt = 0;
    int halt_cnt = 0;

    logic [15:0] app_m [16];
    logic [15:0] prv_m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cmd_engine i_dbg_cmd_engine (
        .clk(clk), .rst_n(rst_n), .opc_valid(opc_valid), .opc(opc),
        .arg_valid(arg_valid), .arg_data(arg_data), .fw_enable(fw_enable),
        .halt_req(halt_req), .halt_done(halt_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_bdsel(mem_bdsel), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .ack(ack), .busy(busy)
    );

    // Memory and processor model
    assign mem_gnt   = mem_req && (wait_cnt >= gnt_delay);
    assign halt_done = halt_req && (halt_cnt >= halt_delay);
    assign mem_rdata = mem_bdsel ? prv_m[mem_addr[4:1]] : app_m[mem_addr[4:1]];

    always @(posedge clk) begin
        wait_cnt <= (mem_req && !mem_gnt) ? wait_cnt + 1 : 0;
        halt_cnt <= (halt_req && !halt_done) ? halt_cnt + 1 : 0;
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) begin
                app_m[k] <= 16'h0000;
                prv_m[k] <= 16'h0000;
            end
        end else if (mem_req && mem_gnt && mem_we) begin
            if (mem_bdsel) begin
                if (mem_be[1]) prv_m[mem_addr[4:1]][15:8] <= mem_wdata[15:8];
                if (mem_be[0]) prv_m[mem_addr[4:1]][7:0]  <= mem_wdata[7:0];
            end else begin
                if (mem_be[1]) app_m[mem_addr[4:1]][15:8] <= mem_wdata[15:8];
                if (mem_be[0]) app_m[mem_addr[4:1]][7:0]  <= mem_wdata[7:0];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output bit s_ack, output bit s_rdv,
                           output bit s_req, output bit s_prv, output bit s_halt, output int cyc);
        bit is_rd, is_wr;
        is_rd = op inside {8'hE0, 8'hE8, 8'hE4, 8'hEC};
        is_wr = op inside {8'hC0, 8'hC8, 8'hC4, 8'hCC};
        rd = 16'h0; s_ack = 0; s_rdv = 0; s_req = 0; s_prv = 0; s_halt = 0; cyc = 0;
        @(negedge clk);
        opc_valid = 1'b1;
        opc = op;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            opc_valid = 1'b0;
            if (i == 0 && (is_rd || is_wr)) begin
                arg_valid = 1'b1; arg_data = a;
            end else if (i == 1 && is_wr) begin
                arg_valid = 1'b1; arg_data = d;
            end else begin
                arg_valid = 1'b0;
            end
            s_ack  |= ack;
            s_req  |= mem_req;
            s_prv  |= mem_bdsel;
            s_halt |= halt_req;
            if (rd_valid) begin
                s_rdv = 1; rd = rd_data;
            end
            cyc = i;
            if (!busy) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        bit s_ack, s_rdv, s_req, s_prv, s_halt;
        int cyc;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(!busy && !ack && !mem_req && !halt_req && !rd_valid, "R9 reset outputs",
              {11'h0, busy, ack, mem_req, halt_req, rd_valid}, 16'h0);
        rst_n = 1'b1;

        // R7: handshake off after reset; R2 read still returns data
        run_cmd(8'hE8, 16'h0000, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(!s_ack, "R7 no ack after reset", 16'(s_ack), 16'h0);
        check(s_rdv && rd == 16'h0000, "R2 read valid after reset", 16'(s_rdv), 16'h1);

        // Vector table: R2 R3 R4 R5 R6
        foreach (VECS[v]) begin
            bit is_rd, is_prv;
            is_rd  = VECS[v].opc inside {8'hE0, 8'hE8, 8'hE4, 8'hEC};
            is_prv = VECS[v].opc inside {8'hE4, 8'hEC, 8'hC4, 8'hCC};
            run_cmd(VECS[v].opc, VECS[v].addr, VECS[v].wdat, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
            check(s_ack == VECS[v].exp_ack, "R6 ack per command", 16'(s_ack), 16'(VECS[v].exp_ack));
            check(s_prv == is_prv, "R5 private select", 16'(s_prv), 16'(is_prv));
            if (is_rd) begin
                check(s_rdv, "R2 rd_valid", 16'(s_rdv), 16'h1);
                check(rd == VECS[v].exp, "R3 R4 read data", rd, VECS[v].exp);
            end
        end

        // R1: unknown opcodes ignored
        run_cmd(8'h00, 16'h0, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(cyc == 0 && !s_req && !s_ack, "R1 opcode 00 ignored", 16'(cyc), 16'h0);
        run_cmd(8'hE1, 16'h0, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(cyc == 0 && !s_req && !s_ack, "R1 opcode E1 ignored", 16'(cyc), 16'h0);
        run_cmd(8'hE8, 16'h0012, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(rd == 16'hABCD, "R1 engine usable after unknown", rd, 16'hABCD);

        // R10 R9: grant after wait states
        gnt_delay = 5;
        run_cmd(8'hE8, 16'h0010, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(cyc == 8, "R9 busy through wait states", 16'(cyc), 16'd8);
        check(rd == 16'h1234 && s_ack, "R10 read data with wait states", rd, 16'h1234);
        run_cmd(8'hC8, 16'h001E, 16'hC0DE, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        gnt_delay = 0;
        run_cmd(8'hE8, 16'h001E, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(rd == 16'hC0DE, "R10 write with wait states", rd, 16'hC0DE);

        // R8: halt gated by firmware enable
        fw_enable = 1'b0;
        run_cmd(8'h90, 16'h0, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(!s_halt && cyc == 0 && !s_ack, "R8 halt ignored without enable", 16'(s_halt), 16'h0);
        fw_enable = 1'b1;
        halt_delay = 3;
        run_cmd(8'h90, 16'h0, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(s_halt && s_ack, "R8 halt requested and acked", 16'(s_halt), 16'h1);
        check(cyc == 5, "R8 ack after entry", 16'(cyc), 16'd5);
        fw_enable = 1'b0;

        // R7: handshake off suppresses pulses
        run_cmd(8'hD6, 16'h0, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(!s_ack, "R7 disable gives no ack", 16'(s_ack), 16'h0);
        run_cmd(8'hC0, 16'h0017, 16'h0042, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(!s_ack, "R7 write without ack", 16'(s_ack), 16'h0);
        run_cmd(8'hE8, 16'h0016, 16'h0, rd, s_ack, s_rdv, s_req, s_prv, s_halt, cyc);
        check(!s_ack && s_rdv && rd == 16'h0042, "R7 read without ack", rd, 16'h0042);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule